// File: doc/BRIEF.md
# Cell-Framed Receive Write Controller

This block sits on the receive side of a four-queue cell buffer. It takes 9-bit words from a cell-oriented receive interface and turns them into write strobes for one of four downstream FIFOs. It only ever fills a queue one whole cell at a time. A cell opens with a start-of-cell flag and closes when a byte counter reaches a cell length. That length is fixed when reset is released. Once a cell is complete, stray bytes are refused until the sender opens a new cell.

The block drives the handshake toward the sender. It raises a room flag when the selected queue has space for a whole cell. It turns each transfer request into a registered enable, and it captures data on the clock edge after that enable is seen. Toward the storage it presents a registered write strobe with the data and queue index. It also gives an end-of-cell pulse with the last byte, and a drop pulse when a new cell replaces a partly written one.

Top module: `cellwr_ctrl`

## Requirements
- R1: While reset is low with `cfg_oe` low, the cell length is 53 bytes; the value present at reset release holds until the next reset, whatever the configuration pins do afterwards.
- R2: With `cfg_oe` high during reset, the length is the 7-bit `cfg_code` (bit 0 least significant); code 0 means 128 bytes and codes 1 to 7 are raised to 8 bytes.
- R3: If `bdi_mode` is high while reset is low, any length above 126 bytes is lowered to 126.
- R4: `cell_avail` is high exactly when the free-word count of the queue named by `rx_fifo_sel` (field i of `fifo_space` is bits 8i+7..8i) is at least the cell length.
- R5: `rx_en` rises one clock after `accept_req` is sampled high, and only if a cell is in progress or `cell_avail` was high at that edge.
- R6: A word sampled on an edge where `rx_en` is high appears on `wr_data` with `wr_stb` high in the following cycle; `wr_fifo` gives the queue latched with that cell's first byte.
- R7: Outside a cell, a word without `rx_soc` is refused, and no write strobe follows it.
- R8: `wr_eoc` pulses together with the strobe of the byte that makes the count equal the cell length; the next word is written only if it carries `rx_soc`.
- R9: Dropping `accept_req` in the middle of a cell pauses writing, and the count resumes from the same byte position.
- R10: A word carrying `rx_soc` while a cell is open is written as byte one of a new cell, and `wr_drop` pulses with its strobe.
- R11: During reset, `rx_en`, `wr_stb`, `wr_eoc` and `wr_drop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the cell length is captured while it is low |
| cfg_oe | input | 1 | Low selects the 53-byte default, high selects `cfg_code` |
| cfg_code | input | 7 | Cell length code, 0 means 128 |
| bdi_mode | input | 1 | Byte insert/delete mode, limits length to 126 |
| fifo_space | input | 32 | Free words per queue, 8 bits per queue |
| rx_fifo_sel | input | 2 | Queue the sender targets |
| accept_req | input | 1 | Request from the controlling agent to transfer this cycle |
| rx_data | input | 9 | Receive word |
| rx_soc | input | 1 | Start-of-cell marker, high with the first byte |
| cell_avail | output | 1 | Selected queue can take a whole cell |
| rx_en | output | 1 | Transfer enable toward the sender |
| wr_stb | output | 1 | Write strobe to storage |
| wr_fifo | output | 2 | Queue index for the write |
| wr_data | output | 9 | Word to write |
| wr_eoc | output | 1 | Last byte of a cell |
| wr_drop | output | 1 | Discard the partial cell in the target queue |

## Verification
`cell_avail` is combinational, so it is compared in the same cycle as the queue selection and free-space inputs that produce it. `rx_en` is due one rising edge after the request. The write strobe, data, end-of-cell and drop outputs come one edge after the capture edge, which is two edges after the request. A reference model in the bench steps at every rising edge from the inputs held since the previous falling edge, and every output is compared at the next falling edge, after exactly one register update. The cell length is checked only through end-of-cell timing, against a length the bench computes from the configuration it drove during reset.

// File: rtl/cellwr_pkg.sv
package cellwr_pkg;
    typedef enum logic {
        CW_IDLE = 1'b0,
        CW_BODY = 1'b1
    } cw_phase_e;
endpackage

// File: rtl/cellwr_len_decode.sv
module cellwr_len_decode #(
    parameter int CODE_W  = 7,
    parameter int LEN_W   = 8,
    parameter int DEF_LEN = 53,
    parameter int MIN_LEN = 8,
    parameter int BDI_LEN = 126
) (
    input  logic              sel_code,
    input  logic [CODE_W-1:0] code,
    input  logic              bdi,
    output logic [LEN_W-1:0]  len
);
    localparam int ZERO_LEN = 1 << CODE_W;

    logic [LEN_W-1:0] raw;

    always_comb begin
        if (!sel_code)
            raw = LEN_W'(DEF_LEN);
        else if (code == '0)
            raw = LEN_W'(ZERO_LEN);
        else if (int'(code) < MIN_LEN)
            raw = LEN_W'(MIN_LEN);
        else
            raw = LEN_W'(code);

        if (bdi && (int'(raw) > BDI_LEN))
            len = LEN_W'(BDI_LEN);
        else
            len = raw;
    end
endmodule

// File: rtl/cellwr_space_check.sv
module cellwr_space_check #(
    parameter int N_FIFO  = 4,
    parameter int SPACE_W = 8,
    parameter int LEN_W   = 8,
    parameter int SEL_W   = 2
) (
    input  logic [N_FIFO*SPACE_W-1:0] space_flat,
    input  logic [SEL_W-1:0]          sel,
    input  logic [LEN_W-1:0]          len,
    output logic                      fits
);
    localparam int CMP_W = (SPACE_W > LEN_W) ? SPACE_W : LEN_W;

    logic [N_FIFO-1:0] fit_vec;

    for (genvar i = 0; i < N_FIFO; i++) begin : g_fit
        assign fit_vec[i] = CMP_W'(space_flat[i*SPACE_W +: SPACE_W]) >= CMP_W'(len);
    end

    assign fits = fit_vec[sel];
endmodule

// File: rtl/cellwr_ctrl.sv
module cellwr_ctrl
    import cellwr_pkg::*;
#(
    parameter int DATA_W  = 9,
    parameter int N_FIFO  = 4,
    parameter int CODE_W  = 7,
    parameter int LEN_W   = 8,
    parameter int SPACE_W = 8,
    parameter int DEF_LEN = 53,
    parameter int MIN_LEN = 8,
    parameter int BDI_LEN = 126,
    localparam int SEL_W  = $clog2(N_FIFO)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_oe,
    input  logic [CODE_W-1:0]         cfg_code,
    input  logic                      bdi_mode,
    input  logic [N_FIFO*SPACE_W-1:0] fifo_space,
    input  logic [SEL_W-1:0]          rx_fifo_sel,
    input  logic                      accept_req,
    input  logic [DATA_W-1:0]         rx_data,
    input  logic                      rx_soc,
    output logic                      cell_avail,
    output logic                      rx_en,
    output logic                      wr_stb,
    output logic [SEL_W-1:0]          wr_fifo,
    output logic [DATA_W-1:0]         wr_data,
    output logic                      wr_eoc,
    output logic                      wr_drop
);
    localparam int MAX_LEN = 1 << CODE_W;

    typedef struct packed {
        logic              en;
        cw_phase_e         phase;
        logic [LEN_W-1:0]  cnt;
        logic [SEL_W-1:0]  tgt;
        logic              stb;
        logic              eoc;
        logic              drop;
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  len;
        logic              bdi;
    } cw_state_t;

    cw_state_t        st_d, st_q;
    logic [LEN_W-1:0] dec_len;
    logic             room;
    logic [LEN_W-1:0] cnt_inc;
    logic             in_body;

    cellwr_len_decode #(
        .CODE_W (CODE_W),
        .LEN_W  (LEN_W),
        .DEF_LEN(DEF_LEN),
        .MIN_LEN(MIN_LEN),
        .BDI_LEN(BDI_LEN)
    ) u_len (
        .sel_code(cfg_oe),
        .code    (cfg_code),
        .bdi     (bdi_mode),
        .len     (dec_len)
    );

    cellwr_space_check #(
        .N_FIFO (N_FIFO),
        .SPACE_W(SPACE_W),
        .LEN_W  (LEN_W),
        .SEL_W  (SEL_W)
    ) u_room (
        .space_flat(fifo_space),
        .sel       (rx_fifo_sel),
        .len       (st_q.len),
        .fits      (room)
    );

    assign in_body = (st_q.phase == CW_BODY);
    assign cnt_inc = st_q.cnt + LEN_W'(1);

    always_comb begin
        st_d      = st_q;
        st_d.stb  = 1'b0;
        st_d.eoc  = 1'b0;
        st_d.drop = 1'b0;

        // capture happens on the edge after the enable was presented
        if (st_q.en) begin
            if (rx_soc) begin
                st_d.drop  = in_body;
                st_d.stb   = 1'b1;
                st_d.data  = rx_data;
                st_d.tgt   = rx_fifo_sel;
                st_d.cnt   = LEN_W'(1);
                st_d.phase = CW_BODY;
            end else if (in_body) begin
                st_d.stb  = 1'b1;
                st_d.data = rx_data;
                st_d.cnt  = cnt_inc;
                if (cnt_inc == st_q.len) begin
                    st_d.eoc   = 1'b1;
                    st_d.phase = CW_IDLE;
                    st_d.cnt   = '0;
                end
            end
        end

        st_d.en = accept_req && (in_body || room);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.len <= dec_len;
            st_q.bdi <= bdi_mode;
        end else begin
            st_q <= st_d;
        end
    end

    assign cell_avail = room;
    assign rx_en      = st_q.en;
    assign wr_stb     = st_q.stb;
    assign wr_fifo    = st_q.tgt;
    assign wr_data    = st_q.data;
    assign wr_eoc     = st_q.eoc;
    assign wr_drop    = st_q.drop;

    // R2
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(st_q.len) >= MIN_LEN) && (int'(st_q.len) <= MAX_LEN));

    // R3
    bdi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bdi |-> (int'(st_q.len) <= BDI_LEN));

    // R5
    en_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !$past(in_body)) |-> $past(cell_avail));

    // R6
    stb_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(rx_en));

    // R8
    cnt_below_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_body |-> (st_q.cnt < st_q.len));

    // R8
    eoc_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eoc |-> wr_stb);

    // R8
    reopen_needs_soc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && $past(wr_eoc)) |-> $past(rx_soc));

    // R10
    drop_in_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |-> (wr_stb && $past(in_body)));
endmodule

// File: tb/sim_cellwr_ctrl.sv
module sim_cellwr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_oe;
    logic [6:0] cfg_code;
    logic       bdi_mode;
    logic [31:0] fifo_space;
    logic [1:0] rx_fifo_sel;
    logic       accept_req;
    logic [8:0] rx_data;
    logic       rx_soc;
    logic       cell_avail, rx_en, wr_stb, wr_eoc, wr_drop;
    logic [1:0] wr_fifo;
    logic [8:0] wr_data;

    always #4 clk = ~clk;

    cellwr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_oe(cfg_oe), .cfg_code(cfg_code),
        .bdi_mode(bdi_mode), .fifo_space(fifo_space), .rx_fifo_sel(rx_fifo_sel),
        .accept_req(accept_req), .rx_data(rx_data), .rx_soc(rx_soc),
        .cell_avail(cell_avail), .rx_en(rx_en), .wr_stb(wr_stb),
        .wr_fifo(wr_fifo), .wr_data(wr_data), .wr_eoc(wr_eoc), .wr_drop(wr_drop)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit m_en, m_in, exp_stb, exp_eoc, exp_drop;
    int m_cnt, m_len, exp_data, exp_fifo;
    string eoc_tag = "R8";
    string stb_tag = "R6";

    function automatic int calc_len(bit oe, int code, bit bdi);
        int l;
        if (!oe) l = 53;
        else if (code == 0) l = 128;
        else if (code < 8) l = 8;
        else l = code;
        if (bdi && l > 126) l = 126;
        return l;
    endfunction

    function automatic bit calc_avail();
        int s;
        s = int'((fifo_space >> (int'(rx_fifo_sel) * 8)) & 32'hFF);
        return s >= m_len;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(bit oe, int code, bit bdi);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_oe = oe; cfg_code = 7'(code); bdi_mode = bdi;
        accept_req = 1'b0; rx_soc = 1'b0; rx_data = '0;
        repeat (3) @(negedge clk);
        m_en = 0; m_in = 0; m_cnt = 0;
        exp_stb = 0; exp_eoc = 0; exp_drop = 0;
        m_len = calc_len(oe, code, bdi);
        chk("R11", int'(rx_en), 0);
        chk("R11", int'(wr_stb), 0);
        chk("R11", int'(wr_eoc), 0);
        chk("R11", int'(wr_drop), 0);
        rst_n = 1'b1;
        // R1: configuration pins are ignored once reset is released
        cfg_oe = ~oe; cfg_code = 7'($urandom); bdi_mode = ~bdi;
    endtask

    task automatic cyc();
        bit av, old_in;
        @(posedge clk);
        av = calc_avail();
        old_in = m_in;
        exp_stb = 0; exp_eoc = 0; exp_drop = 0;
        if (m_en) begin
            if (rx_soc) begin
                exp_drop = old_in; exp_stb = 1;
                exp_data = int'(rx_data); exp_fifo = int'(rx_fifo_sel);
                m_cnt = 1; m_in = 1;
            end else if (old_in) begin
                exp_stb = 1; exp_data = int'(rx_data);
                m_cnt++;
                if (m_cnt == m_len) begin
                    exp_eoc = 1; m_in = 0; m_cnt = 0;
                end
            end
        end
        m_en = accept_req && (old_in || av);
        @(negedge clk);
        chk("R5", int'(rx_en), int'(m_en));
        chk(stb_tag, int'(wr_stb), int'(exp_stb));
        chk(eoc_tag, int'(wr_eoc), int'(exp_eoc));
        chk("R10", int'(wr_drop), int'(exp_drop));
        if (exp_stb) begin
            chk("R6", int'(wr_data), exp_data);
            chk("R6", int'(wr_fifo), exp_fifo);
        end
        chk("R4", int'(cell_avail), int'(calc_avail()));
    endtask

    task automatic send_cell(int n, int pause_pct, int sel);
        int bytes = 0;
        int guard = 0;
        rx_fifo_sel = 2'(sel);
        while (bytes < n && guard < 1000) begin
            accept_req = (($urandom % 100) >= pause_pct);
            rx_soc = m_en && (bytes == 0);
            rx_data = 9'($urandom);
            if (m_en) bytes++;
            cyc();
            guard++;
        end
        accept_req = 1'b0; rx_soc = 1'b0;
        repeat (2) cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        fifo_space = '1; rx_fifo_sel = '0;
        accept_req = 1'b0; rx_soc = 1'b0; rx_data = '0;
        cfg_oe = 1'b0; cfg_code = '0; bdi_mode = 1'b0;

        // R1 default length
        eoc_tag = "R1";
        do_reset(1'b0, 0, 1'b0);
        send_cell(53, 0, 1);

        // R2 code zero gives 128
        eoc_tag = "R2";
        do_reset(1'b1, 0, 1'b0);
        send_cell(128, 0, 2);

        // R2 small code raised to 8, then R7 refusal after the cell
        do_reset(1'b1, 5, 1'b0);
        send_cell(8, 0, 3);
        stb_tag = "R7";
        accept_req = 1'b1; rx_soc = 1'b0;
        for (int i = 0; i < 6; i++) begin
            rx_data = 9'($urandom);
            cyc();
        end
        accept_req = 1'b0;
        repeat (2) cyc();
        stb_tag = "R6";

        // R9 pauses inside a cell
        eoc_tag = "R9";
        do_reset(1'b1, 20, 1'b0);
        send_cell(20, 40, 0);
        send_cell(20, 60, 1);

        // R10 new start while a cell is open
        eoc_tag = "R8";
        send_cell(9, 0, 2);
        send_cell(20, 0, 2);

        // R3 insert/delete limit
        eoc_tag = "R3";
        do_reset(1'b1, 0, 1'b1);
        send_cell(126, 0, 0);
        do_reset(1'b1, 100, 1'b1);
        send_cell(100, 0, 1);

        // R4 and R5: target queue too small, no enable
        eoc_tag = "R8";
        fifo_space = {8'd255, 8'd19, 8'd100, 8'd20};
        rx_fifo_sel = 2'd2;
        accept_req = 1'b1;
        for (int i = 0; i < 5; i++) cyc();
        rx_fifo_sel = 2'd0;
        for (int i = 0; i < 3; i++) cyc();
        accept_req = 1'b0;
        repeat (2) cyc();

        // random traffic
        do_reset(1'b1, int'($urandom % 32), 1'b0);
        for (int i = 0; i < 4000; i++) begin
            if ((i % 50) == 0)
                fifo_space = {8'($urandom), 8'd255, 8'($urandom), 8'd200};
            accept_req = (($urandom % 100) < 80);
            rx_soc = (($urandom % 100) < 8);
            rx_fifo_sel = 2'($urandom);
            rx_data = 9'($urandom);
            cyc();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule